// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a down counter that must be refreshed inside a time window. A refresh that comes too late lets the counter's top bit fall, and a refresh that comes too early, while the counter still sits above a programmed window value, is treated as a fault in the same way. Either fault raises a reset request, which is a stretched pulse, and sets a sticky cause flag that software reads and clears after the restart.

A free-running prescaler divides the bus clock by 2^PRE_W and then by 1, 2, 4 or 8, and produces the tick that decrements the counter. A one-clock early warning fires when the counter reaches the value just above the reset boundary. That leaves software one tick to react. Software controls the block through three write strobes. The control write loads the counter and may set the enable. The config write sets the window value and the divider. The flag-clear strobe clears the cause flag.

Top module: `win_wdog`

## Requirements
- R1: After reset the counter reads 0x7F, the window is 0x7F, the divider selects 1, the watchdog is disabled, and the reset request, early warning and cause flag are all low.
- R2: While enabled, the counter decrements by one on each tick, and a tick occurs every 2^(PRE_W+d) clocks, where d is `cfg_div` (0..3). The prescaler runs from reset. While disabled, the counter holds its value.
- R3: A control write while the counter is at or below the window loads `ctl_data[6:0]` into the counter. It takes priority over a tick in the same cycle, and when it is legal it raises no reset.
- R4: A control write while enabled and while the counter is above the window leaves the counter unchanged and raises a reset request.
- R5: A tick that takes the counter from 0x40 to 0x3F raises a reset request.
- R6: A legal control write that leaves the watchdog enabled and loads a value with bit 6 clear raises a reset request.
- R7: `early_o` is high for exactly one clock, in the clock after a tick brings the counter to 0x40.
- R8: The reset request goes high in the clock after a fault and stays high for RST_LEN clocks. A new fault during the pulse restarts the count.
- R9: The cause flag sets on any fault. Only `flag_clr` clears it, and a fault in the same cycle as `flag_clr` wins.
- R10: Setting `ctl_data[7]` in a control write enables the watchdog. A control write with bit 7 clear does not disable it, so only the block's reset disables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe (refresh/load) |
| ctl_data | input | CNT_W+1 | Bit 7 sets enable; bits 6:0 are the counter load value |
| cfg_we | input | 1 | Config write strobe |
| cfg_win | input | CNT_W | Window value |
| cfg_div | input | 2 | Extra tick divider select: 1, 2, 4, 8 |
| flag_clr | input | 1 | Clears the cause flag |
| wdg_rst_o | output | 1 | Stretched reset request |
| early_o | output | 1 | One-clock early warning |
| rst_flag_o | output | 1 | Sticky cause flag |
| cnt_o | output | CNT_W | Current counter value |

## Verification
A refresh write and a prescaler tick can land on the same clock edge. So can a refresh and the tick that would cross 0x40 to 0x3F. The bench sweeps the offset of a refresh across a whole tick period, one clock at a time, so that the write meets the tick edge exactly. A behavioural reference model, which gives the write priority, judges every cycle: the counter must show the loaded value, with no decrement and no reset. In a second collision, `flag_clr` arrives together with a fault, and the flag must stay set.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
   localparam int DIV_SEL_W = 2;
   localparam int DIV_STEPS = 1 << DIV_SEL_W;
   typedef enum logic [DIV_SEL_W-1:0] {
      DIV_BY1 = 2'd0,
      DIV_BY2 = 2'd1,
      DIV_BY4 = 2'd2,
      DIV_BY8 = 2'd3
   } wwd_div_e;
endpackage

// File: rtl/wwd_prescale.sv
module wwd_prescale #(
   parameter int PRE_W = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          run,
   input  wwd_pkg::wwd_div_e             div,
   output logic                          tick
);
   import wwd_pkg::*;
   localparam int TOT_W = PRE_W + DIV_STEPS - 1;

   logic [TOT_W-1:0]     pre_q;
   logic [DIV_STEPS-1:0] all_ones;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   // one terminal-count detector per divider step
   for (genvar k = 0; k < DIV_STEPS; k++) begin : g_step
      assign all_ones[k] = &pre_q[PRE_W+k-1:0];
   end

   assign tick = run & all_ones[div];
endmodule

// File: rtl/wwd_core.sv
module wwd_core #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld_we,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] win,
   output logic [CNT_W-1:0] cnt,
   output logic             en,
   output logic             fault,
   output logic             early
);
   localparam int MSB = CNT_W - 1;
   localparam logic [CNT_W-1:0] BOUND = CNT_W'(1) << MSB;

   logic             too_soon, load_ok, en_nxt, bad_load, dec, timeout;
   logic [CNT_W-1:0] cnt_dec;

   always_comb begin
      too_soon = ld_we && en && (cnt > win);
      load_ok  = ld_we && !too_soon;
      en_nxt   = en | (load_ok & ld_en);
      bad_load = load_ok && en_nxt && !ld_val[MSB];
      dec      = !ld_we && en && tick;
      cnt_dec  = cnt - 1'b1;
      timeout  = dec && cnt[MSB] && !cnt_dec[MSB];
      fault    = too_soon | bad_load | timeout;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '1;
         en    <= 1'b0;
         early <= 1'b0;
      end else begin
         if (load_ok)  cnt <= ld_val;
         else if (dec) cnt <= cnt_dec;
         en    <= en_nxt;
         early <= dec && (cnt_dec == BOUND);
      end
   end

   assert_en_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> en);
   assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ld_we) |=> $stable(cnt));
   assert_early_at_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      early |-> (cnt == BOUND));
   assert_soon_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_we && en && (cnt > win)) |=> $stable(cnt));
endmodule

// File: rtl/wwd_pulse.sv
module wwd_pulse #(
   parameter int RST_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fault,
   input  logic flag_clr,
   output logic rst_req,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (fault)    flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   if (RST_LEN == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rst_req <= 1'b0;
         else        rst_req <= fault;
      end
   end else begin : g_stretch
      localparam int RC_W = $clog2(RST_LEN + 1);
      logic [RC_W-1:0] rc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          rc_q <= '0;
         else if (fault)      rc_q <= RC_W'(RST_LEN);
         else if (rc_q != '0) rc_q <= rc_q - 1'b1;
      end
      assign rst_req = (rc_q != '0);
      assert_hold_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(rst_req)) |=> rst_req);
   end

   assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> rst_req);
   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> flag);
   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/win_wdog.sv
module win_wdog #(
   parameter int CNT_W   = 7,
   parameter int PRE_W   = 12,
   parameter int RST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CNT_W:0]   ctl_data,
   input  logic             cfg_we,
   input  logic [CNT_W-1:0] cfg_win,
   input  logic [1:0]       cfg_div,
   input  logic             flag_clr,
   output logic             wdg_rst_o,
   output logic             early_o,
   output logic             rst_flag_o,
   output logic [CNT_W-1:0] cnt_o
);
   import wwd_pkg::*;

   if (CNT_W < 2)   begin : g_bad_cnt $error("CNT_W must be at least 2"); end
   if (PRE_W < 1)   begin : g_bad_pre $error("PRE_W must be at least 1"); end
   if (RST_LEN < 1) begin : g_bad_len $error("RST_LEN must be at least 1"); end

   logic [CNT_W-1:0] win_q;
   wwd_div_e         div_q;
   logic             tick, en, fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '1;
         div_q <= DIV_BY1;
      end else if (cfg_we) begin
         win_q <= cfg_win;
         div_q <= wwd_div_e'(cfg_div);
      end
   end

   wwd_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(en), .div(div_q), .tick(tick)
   );

   wwd_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ld_we(ctl_we),
      .ld_val(ctl_data[CNT_W-1:0]), .ld_en(ctl_data[CNT_W]), .win(win_q),
      .cnt(cnt_o), .en(en), .fault(fault), .early(early_o)
   );

   wwd_pulse #(.RST_LEN(RST_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fault(fault), .flag_clr(flag_clr),
      .rst_req(wdg_rst_o), .flag(rst_flag_o)
   );
endmodule

// File: tb/win_wdog_bench.sv
module win_wdog_bench;
   localparam int PRE_W = 3;
   localparam int RLEN  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_data = '0;
   logic       cfg_we = 1'b0;
   logic [6:0] cfg_win = '0;
   logic [1:0] cfg_div = '0;
   logic       flag_clr = 1'b0;
   logic       wdg_rst_o, early_o, rst_flag_o;
   logic [6:0] cnt_o;

   always #2 clk = ~clk;

   win_wdog #(.CNT_W(7), .PRE_W(PRE_W), .RST_LEN(RLEN)) u_win_wdog (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
      .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_div(cfg_div), .flag_clr(flag_clr),
      .wdg_rst_o(wdg_rst_o), .early_o(early_o), .rst_flag_o(rst_flag_o), .cnt_o(cnt_o)
   );

   int compared = 0, mismatched = 0, cycles = 0;

   task automatic chk(string req, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   // behavioural reference model
   int m_cnt, m_en, m_win, m_sel, m_pre, m_rc, m_flag, m_early, per;
   bit tk, trig;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 127; m_en = 0; m_win = 127; m_sel = 0;
         m_pre = 0; m_rc = 0; m_flag = 0; m_early = 0;
      end else begin
         per  = 1 << (PRE_W + m_sel);
         tk   = (m_en != 0) && ((m_pre % per) == per - 1);
         trig = 0; m_early = 0;
         if (ctl_we) begin
            if (m_en != 0 && m_cnt > m_win) trig = 1;
            else begin
               m_cnt = int'(ctl_data[6:0]);
               if (ctl_data[7]) m_en = 1;
               if (m_en != 0 && !ctl_data[6]) trig = 1;
            end
         end else if (tk) begin
            if (m_cnt == 64) trig = 1;
            m_cnt = (m_cnt + 127) % 128;
            if (m_cnt == 64) m_early = 1;
         end
         if (cfg_we) begin m_win = int'(cfg_win); m_sel = int'(cfg_div); end
         if (trig) m_rc = RLEN; else if (m_rc > 0) m_rc--;
         if (trig) m_flag = 1; else if (flag_clr) m_flag = 0;
         m_pre = (m_pre + 1) % (1 << (PRE_W + 3));
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 counter", int'(cnt_o), m_cnt);
         chk("R8 reset pulse", int'(wdg_rst_o), (m_rc != 0) ? 1 : 0);
         chk("R7 early warning", int'(early_o), m_early);
         chk("R9 cause flag", int'(rst_flag_o), m_flag);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         mismatched++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(logic [7:0] v);
      ctl_we = 1'b1; ctl_data = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic wr_cfg(logic [6:0] w, logic [1:0] d);
      cfg_we = 1'b1; cfg_win = w; cfg_div = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      int hi;
      cyc(5);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 cnt", int'(cnt_o), 127);
      chk("R1 rst", int'(wdg_rst_o), 0);
      chk("R1 early", int'(early_o), 0);
      chk("R1 flag", int'(rst_flag_o), 0);
      // R2 disabled holds
      cyc(50);
      chk("R2 disabled hold", int'(cnt_o), 127);
      // R5 late refresh: enable at 0x45 and let it expire
      wr_ctl(8'hC5);
      chk("R3 load", int'(cnt_o), 8'h45);
      cyc(60);
      chk("R5 timeout flag", int'(rst_flag_o), 1);
      flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
      chk("R9 clear", int'(rst_flag_o), 0);
      // R10 write with enable bit clear keeps running
      wr_ctl(8'h7F);
      cyc(40);
      chk("R10 still enabled", (cnt_o < 7'h7F) ? 1 : 0, 1);
      // R4 early refresh
      wr_ctl(8'h7F);
      wr_cfg(7'h50, 2'd0);
      wr_ctl(8'h60);
      chk("R4 no load", (cnt_o == 7'h60) ? 1 : 0, 0);
      chk("R4 reset", int'(wdg_rst_o), 1);
      hi = 1;
      for (int i = 0; i < 8; i++) begin
         cyc(1);
         hi += int'(wdg_rst_o);
      end
      chk("R8 pulse length", hi, RLEN);
      // R3 legal refresh inside window
      for (int i = 0; i < 400 && cnt_o > 7'h50; i++) cyc(1);
      wr_ctl(8'h70);
      chk("R3 legal load", int'(cnt_o), 8'h70);
      chk("R3 no reset", int'(wdg_rst_o), 0);
      // R6 load with bit 6 clear
      wr_cfg(7'h7F, 2'd0);
      wr_ctl(8'h20);
      chk("R6 reset", int'(wdg_rst_o), 1);
      chk("R6 loaded", int'(cnt_o), 8'h20);
      cyc(8);
      // collision sweep: refresh against tick edges (R3)
      for (int off = 0; off < 10; off++) begin
         wr_ctl(8'h48);
         cyc(off);
         wr_ctl(8'h41);
         chk("R3 collide load", int'(cnt_o), 8'h41);
         cyc(off);
      end
      // refresh exactly around the 0x40 crossing
      for (int off = 0; off < 10; off++) begin
         wr_ctl(8'h41);
         cyc(8 + off);
         wr_ctl(8'h7F);
         cyc(6);
      end
      // R8 retrigger and R9 clear against fault
      wr_cfg(7'h00, 2'd0);
      wr_ctl(8'h7F);
      cyc(1);
      flag_clr = 1'b1;
      wr_ctl(8'h7F);
      flag_clr = 1'b0;
      chk("R9 fault wins", int'(rst_flag_o), 1);
      cyc(10);
      // R2 slower divider
      wr_cfg(7'h7F, 2'd3);
      wr_ctl(8'h7F);
      cyc(2000);
      wr_cfg(7'h7F, 2'd1);
      wr_ctl(8'h7F);
      cyc(600);
      summary();
      $finish;
   end
endmodule